// File: doc/BRIEF.md
# Per-Thread Squash and Trap Sequencer

This block runs the recovery bookkeeping of a multithreaded out-of-order core, one state machine per hardware thread. Each machine tracks the youngest sequence number it has accepted for its thread. It also takes three kinds of recovery request:

- squash requests from the execute stage;
- trap requests, which fire after a programmable number of cycles;
- context-change squash requests.

Whenever a squash is taken, the block drives a per-thread broadcast to the rest of the pipeline. The broadcast carries a one-cycle squash pulse, the sequence number of the oldest surviving instruction, a redirect PC and a mispredict flag. A separate level flag stays high while the reorder buffer is still discarding entries for that thread.

The per-thread states are Idle (code 0), Running (1), RobSquash (2), TrapWait (3) and FetchTrapWait (4). The named transitions are:

- Activate: Idle to Running.
- Deactivate: Running to Idle.
- ArmTrap: Running to TrapWait, or to FetchTrapWait for a fetch-side trap.
- ExecSquash: to RobSquash.
- FullSquash: to RobSquash, from any state.
- SquashDone: RobSquash to Running.

The reorder buffer reports its head sequence number, whether it is empty, and when it has finished squashing. The committed PC of each thread comes in on an input port.

Top module: `squash_seq_top`

## Requirements
- R1: An execute squash for a thread is taken only when the thread is not in TrapWait (3) or FetchTrapWait (4) and its sequence number is less than or equal to the thread's youngest recorded number. A refused request produces no broadcast pulse and leaves the youngest number unchanged.
- R2: When the include-self bit of an execute squash is set, the broadcast sequence number and the new youngest number are the request number minus one. Otherwise both are the request number itself.
- R3: A taken execute squash produces a one-cycle squash pulse after the request edge, carrying the request's PC and mispredict bit. On the same edge the thread enters RobSquash (2).
- R4: A trap request in Running with latency L (0 behaves as 1) moves the thread to TrapWait (3), or to FetchTrapWait (4) when the fetch bit is set. The full-thread squash pulse appears L+1 clock edges after the request edge. Execute squashes for that thread are refused while it waits.
- R5: If the trap flag and the context flag are pending together, the trap squash is broadcast first and the context squash on the next cycle. A lone context request is broadcast two edges after its request edge.
- R6: A full-thread squash (trap or context) broadcasts the ROB head number minus one, or 0 when the ROB is empty. It uses the thread's committed PC and a cleared mispredict bit, sets the youngest number to 0, and enters RobSquash.
- R7: The ROB-squashing flag is high in every cycle the thread is in RobSquash. The thread returns to Running on the edge where the ROB reports squash done.
- R8: A renamed instruction updates its thread's youngest number only if it is not marked killed and the thread is neither in RobSquash nor entering it on that edge.
- R9: The mispredict counter grows by one for each taken execute squash whose mispredict bit is set. Otherwise it stays unchanged.
- R10: After reset every thread is Idle, the youngest numbers, the counter and the squash pulses are zero, and no trap or context request is pending.
- R11: An Idle thread moves to Running when its active input is high. A Running thread with its active input low and no trap request returns to Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_active | input | NTHR | Thread enable per thread |
| ex_sq_vld | input | NTHR | Execute squash request per thread |
| ex_sq_seq | input | NTHR*SEQW | Squash sequence number per thread |
| ex_sq_self | input | NTHR | Include-self bit per thread |
| ex_sq_mispred | input | NTHR | Mispredict bit per thread |
| ex_sq_pc | input | NTHR*PCW | Redirect PC per thread |
| trap_req | input | NTHR | Trap request per thread |
| trap_fetch | input | NTHR | Trap is fetch-side |
| trap_lat | input | LATW | Trap latency in cycles |
| ctx_sq_req | input | NTHR | Context-change squash request |
| rob_empty | input | NTHR | ROB holds nothing for the thread |
| rob_head_seq | input | NTHR*SEQW | ROB head sequence number |
| rob_sq_done | input | NTHR | ROB finished squashing the thread |
| commit_pc | input | NTHR*PCW | Committed PC per thread |
| ren_vld | input | 1 | Renamed instruction valid |
| ren_tid | input | TIDW | Renamed instruction thread |
| ren_killed | input | 1 | Renamed instruction already squashed |
| ren_seq | input | SEQW | Renamed instruction sequence number |
| bc_sq | output | NTHR | One-cycle squash pulse |
| bc_seq | output | NTHR*SEQW | Broadcast surviving sequence number |
| bc_pc | output | NTHR*PCW | Broadcast redirect PC |
| bc_mispred | output | NTHR | Broadcast mispredict bit |
| bc_robsq | output | NTHR | ROB-squashing flag |
| thr_state | output | NTHR*3 | Thread state code |
| youngest | output | NTHR*SEQW | Youngest recorded sequence number |
| mispred_cnt | output | CNTW | Mispredict event count |

## Verification
Execute squashes are tried with a number above the youngest, with a number equal to it (the boundary), with a number below it, and with the include-self bit set. Together these separate the filter from the minus-one adjustment. Traps are applied with latency 3 and with latency 0, plus a fetch-side trap, which pins the L+1 edge timing and the clamp of 0 to 1. A trap and a context request are lined up so that both flags are pending on the same edge, which shows that the context squash waits rather than being lost. Renames arrive killed, during RobSquash, and normally, each against the youngest number.

// File: rtl/sqs_pkg.sv
package sqs_pkg;

    typedef enum logic [2:0] {
        TS_IDLE   = 3'd0,
        TS_RUN    = 3'd1,
        TS_ROBSQ  = 3'd2,
        TS_TRAPW  = 3'd3,
        TS_FTRAPW = 3'd4
    } thr_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TRAP = 2'd1,
        SRC_CTX  = 2'd2,
        SRC_EXEC = 2'd3
    } sq_src_e;

endpackage

// File: rtl/sqs_trap_timer.sv
module sqs_trap_timer #(
    parameter int LATW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [LATW-1:0] lat,
    output logic            fire
);
    logic [LATW-1:0] cnt_q;
    logic [LATW-1:0] load_val;

    assign load_val = (lat == '0) ? LATW'(1) : lat;
    assign fire     = (cnt_q == LATW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm && cnt_q == '0) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LATW'(1);
        end
    end

    AST_TIMER_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > LATW'(1)) |=> (cnt_q == $past(cnt_q) - LATW'(1))); // R4

endmodule

// File: rtl/sqs_thread.sv
module sqs_thread
    import sqs_pkg::*;
#(
    parameter int SEQW = 16,
    parameter int PCW  = 32,
    parameter int LATW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            act,
    input  logic            ex_vld,
    input  logic [SEQW-1:0] ex_seq,
    input  logic            ex_self,
    input  logic            ex_mis,
    input  logic [PCW-1:0]  ex_pc,
    input  logic            trap_req,
    input  logic            trap_fetch,
    input  logic [LATW-1:0] trap_lat,
    input  logic            ctx_req,
    input  logic            rob_empty,
    input  logic [SEQW-1:0] head_seq,
    input  logic            rob_sq_done,
    input  logic [PCW-1:0]  commit_pc,
    input  logic            ren_hit,
    input  logic            ren_killed,
    input  logic [SEQW-1:0] ren_seq,
    output thr_state_e      state_o,
    output logic [SEQW-1:0] youngest_o,
    output logic            bc_sq_o,
    output logic [SEQW-1:0] bc_seq_o,
    output logic [PCW-1:0]  bc_pc_o,
    output logic            bc_mis_o,
    output logic            bc_robsq_o,
    output logic            mis_evt_o
);
    thr_state_e      state_q, state_n;
    logic [SEQW-1:0] youngest_q;
    logic            trap_flag_q, ctx_flag_q;
    logic            timer_fire, timer_arm;
    logic            waiting, ex_ok, full;
    logic [SEQW-1:0] ex_eff, full_seq;
    sq_src_e         src;

    sqs_trap_timer #(.LATW(LATW)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (timer_arm),
        .lat   (trap_lat),
        .fire  (timer_fire)
    );

    // squash source selection: trap beats context beats execute
    assign waiting  = (state_q == TS_TRAPW) || (state_q == TS_FTRAPW);
    assign full     = trap_flag_q || ctx_flag_q;
    assign ex_eff   = ex_self ? (ex_seq - SEQW'(1)) : ex_seq;
    assign full_seq = rob_empty ? '0 : (head_seq - SEQW'(1));
    assign ex_ok    = ex_vld && !full && !waiting && (ex_seq <= youngest_q);

    always_comb begin
        if (trap_flag_q)     src = SRC_TRAP;
        else if (ctx_flag_q) src = SRC_CTX;
        else if (ex_ok)      src = SRC_EXEC;
        else                 src = SRC_NONE;
    end

    // next-state process
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            TS_IDLE:   if (act) state_n = TS_RUN;
            TS_RUN: begin
                if (trap_req)  state_n = trap_fetch ? TS_FTRAPW : TS_TRAPW;
                else if (!act) state_n = TS_IDLE;
            end
            TS_ROBSQ:  if (rob_sq_done) state_n = TS_RUN;
            TS_TRAPW:  state_n = TS_TRAPW;
            TS_FTRAPW: state_n = TS_FTRAPW;
            default:   state_n = TS_IDLE;
        endcase
        if (src != SRC_NONE) state_n = TS_ROBSQ;
    end

    assign timer_arm = (state_q == TS_RUN) && trap_req && (src == SRC_NONE);

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= TS_IDLE;
            trap_flag_q <= 1'b0;
            ctx_flag_q  <= 1'b0;
        end else begin
            state_q     <= state_n;
            trap_flag_q <= timer_fire;
            ctx_flag_q  <= ctx_req || (ctx_flag_q && trap_flag_q);
        end
    end

    // output / bookkeeping process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            youngest_q <= '0;
            bc_sq_o    <= 1'b0;
            bc_seq_o   <= '0;
            bc_pc_o    <= '0;
            bc_mis_o   <= 1'b0;
        end else begin
            bc_sq_o <= (src != SRC_NONE);
            unique case (src)
                SRC_TRAP, SRC_CTX: begin
                    youngest_q <= '0;
                    bc_seq_o   <= full_seq;
                    bc_pc_o    <= commit_pc;
                    bc_mis_o   <= 1'b0;
                end
                SRC_EXEC: begin
                    youngest_q <= ex_eff;
                    bc_seq_o   <= ex_eff;
                    bc_pc_o    <= ex_pc;
                    bc_mis_o   <= ex_mis;
                end
                SRC_NONE: begin
                    if (ren_hit && !ren_killed && state_n != TS_ROBSQ)
                        youngest_q <= ren_seq;
                end
                default: ;
            endcase
        end
    end

    assign state_o    = state_q;
    assign youngest_o = youngest_q;
    assign bc_robsq_o = (state_q == TS_ROBSQ);
    assign mis_evt_o  = (src == SRC_EXEC) && ex_mis;

    AST_EX_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_vld && (ex_seq > youngest_q) && !trap_flag_q && !ctx_flag_q) |=> !bc_sq_o); // R1
    AST_SQ_ENTERS_ROBSQ: assert property (@(posedge clk) disable iff (!rst_n)
        bc_sq_o |-> (state_q == TS_ROBSQ)); // R3
    AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == TS_TRAPW) && !trap_flag_q && !ctx_flag_q) |=> (state_q == TS_TRAPW)); // R4
    AST_CTX_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_flag_q && ctx_flag_q) |=> ctx_flag_q); // R5
    AST_FULL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_flag_q || ctx_flag_q) |=> (youngest_q == '0)); // R6
    AST_ROBSQ_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == TS_ROBSQ) && !rob_sq_done) |=> (state_q == TS_ROBSQ)); // R7

endmodule

// File: rtl/squash_seq_top.sv
module squash_seq_top
    import sqs_pkg::*;
#(
    parameter int NTHR = 2,
    parameter int SEQW = 16,
    parameter int PCW  = 32,
    parameter int LATW = 4,
    parameter int CNTW = 8,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NTHR-1:0]      thr_active,
    input  logic [NTHR-1:0]      ex_sq_vld,
    input  logic [NTHR*SEQW-1:0] ex_sq_seq,
    input  logic [NTHR-1:0]      ex_sq_self,
    input  logic [NTHR-1:0]      ex_sq_mispred,
    input  logic [NTHR*PCW-1:0]  ex_sq_pc,
    input  logic [NTHR-1:0]      trap_req,
    input  logic [NTHR-1:0]      trap_fetch,
    input  logic [LATW-1:0]      trap_lat,
    input  logic [NTHR-1:0]      ctx_sq_req,
    input  logic [NTHR-1:0]      rob_empty,
    input  logic [NTHR*SEQW-1:0] rob_head_seq,
    input  logic [NTHR-1:0]      rob_sq_done,
    input  logic [NTHR*PCW-1:0]  commit_pc,
    input  logic                 ren_vld,
    input  logic [TIDW-1:0]      ren_tid,
    input  logic                 ren_killed,
    input  logic [SEQW-1:0]      ren_seq,
    output logic [NTHR-1:0]      bc_sq,
    output logic [NTHR*SEQW-1:0] bc_seq,
    output logic [NTHR*PCW-1:0]  bc_pc,
    output logic [NTHR-1:0]      bc_mispred,
    output logic [NTHR-1:0]      bc_robsq,
    output logic [NTHR*3-1:0]    thr_state,
    output logic [NTHR*SEQW-1:0] youngest,
    output logic [CNTW-1:0]      mispred_cnt
);
    logic [NTHR-1:0] mis_evt;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        thr_state_e st;
        logic       hit;

        assign hit = ren_vld && (ren_tid == TIDW'(t));

        sqs_thread #(.SEQW(SEQW), .PCW(PCW), .LATW(LATW)) thr_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .act         (thr_active[t]),
            .ex_vld      (ex_sq_vld[t]),
            .ex_seq      (ex_sq_seq[t*SEQW +: SEQW]),
            .ex_self     (ex_sq_self[t]),
            .ex_mis      (ex_sq_mispred[t]),
            .ex_pc       (ex_sq_pc[t*PCW +: PCW]),
            .trap_req    (trap_req[t]),
            .trap_fetch  (trap_fetch[t]),
            .trap_lat    (trap_lat),
            .ctx_req     (ctx_sq_req[t]),
            .rob_empty   (rob_empty[t]),
            .head_seq    (rob_head_seq[t*SEQW +: SEQW]),
            .rob_sq_done (rob_sq_done[t]),
            .commit_pc   (commit_pc[t*PCW +: PCW]),
            .ren_hit     (hit),
            .ren_killed  (ren_killed),
            .ren_seq     (ren_seq),
            .state_o     (st),
            .youngest_o  (youngest[t*SEQW +: SEQW]),
            .bc_sq_o     (bc_sq[t]),
            .bc_seq_o    (bc_seq[t*SEQW +: SEQW]),
            .bc_pc_o     (bc_pc[t*PCW +: PCW]),
            .bc_mis_o    (bc_mispred[t]),
            .bc_robsq_o  (bc_robsq[t]),
            .mis_evt_o   (mis_evt[t])
        );

        assign thr_state[t*3 +: 3] = st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mispred_cnt <= '0;
        else        mispred_cnt <= mispred_cnt + CNTW'($countones(mis_evt));
    end

    AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_evt == '0) |=> $stable(mispred_cnt)); // R9
    AST_CNT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_evt != '0) |=> (mispred_cnt != $past(mispred_cnt))); // R9

endmodule

// File: tb/squash_seq_top_tb_top.sv
`timescale 1ns/1ps
module squash_seq_top_tb_top;
    localparam int NT = 2, SW = 16, PW = 32, LW = 4, CW = 8, TW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0] thr_active = '0, ex_sq_vld = '0, ex_sq_self = '0, ex_sq_mispred = '0;
    logic [NT*SW-1:0] ex_sq_seq = '0, rob_head_seq = '0;
    logic [NT*PW-1:0] ex_sq_pc = '0, commit_pc = '0;
    logic [NT-1:0] trap_req = '0, trap_fetch = '0, ctx_sq_req = '0, rob_empty = '1, rob_sq_done = '0;
    logic [LW-1:0] trap_lat = '0;
    logic ren_vld = 1'b0, ren_killed = 1'b0;
    logic [TW-1:0] ren_tid = '0;
    logic [SW-1:0] ren_seq = '0;
    logic [NT-1:0] bc_sq, bc_mispred, bc_robsq;
    logic [NT*SW-1:0] bc_seq, youngest;
    logic [NT*PW-1:0] bc_pc;
    logic [NT*3-1:0] thr_state;
    logic [CW-1:0] mispred_cnt;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    typedef struct { int tid; logic [SW-1:0] seq; logic [PW-1:0] pc; logic mis; } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    squash_seq_top #(.NTHR(NT), .SEQW(SW), .PCW(PW), .LATW(LW), .CNTW(CW)) dut_i (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic push(int t, logic [SW-1:0] s, logic [PW-1:0] p, logic m);
        exp_t e;
        e.tid = t; e.seq = s; e.pc = p; e.mis = m;
        sb.push_back(e);
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    function automatic logic [2:0] st(int t);
        return thr_state[t*3 +: 3];
    endfunction

    function automatic logic [SW-1:0] yg(int t);
        return youngest[t*SW +: SW];
    endfunction

    // monitor: pops expected broadcasts as they appear
    always @(negedge clk) begin
        if (rst_n) begin
            for (int t = 0; t < NT; t++) begin
                if (bc_sq[t]) begin
                    if (sb.size() == 0) begin
                        chk("R3 unexpected squash pulse", 64'(t), 64'hFF);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        chk("R3 pulse thread", 64'(t), 64'(e.tid));
                        chk("R2/R6 broadcast seq", 64'(bc_seq[t*SW +: SW]), 64'(e.seq));
                        chk("R3/R6 broadcast pc", 64'(bc_pc[t*PW +: PW]), 64'(e.pc));
                        chk("R3/R6 broadcast mispred", 64'(bc_mispred[t]), 64'(e.mis));
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 state t0", 64'(st(0)), 64'd0);
        chk("R10 state t1", 64'(st(1)), 64'd0);
        chk("R10 youngest", 64'(youngest), 64'd0);
        chk("R10 pulses", 64'(bc_sq), 64'd0);
        chk("R10 counter", 64'(mispred_cnt), 64'd0);

        thr_active = 2'b11; cyc();
        chk("R11 idle to running", 64'(st(0)), 64'd1);

        // R8 renames
        ren_vld = 1; ren_tid = 0; ren_seq = 10; cyc();
        ren_tid = 1; ren_seq = 20; cyc();
        ren_tid = 0; ren_seq = 99; ren_killed = 1; cyc();
        ren_vld = 0; ren_killed = 0;
        chk("R8 youngest t0 (killed ignored)", 64'(yg(0)), 64'd10);
        chk("R8 youngest t1", 64'(yg(1)), 64'd20);

        // R1 too-young squash refused
        ex_sq_vld[0] = 1; ex_sq_seq[0 +: SW] = 12; ex_sq_mispred[0] = 1; cyc();
        ex_sq_vld = 0;
        chk("R1 refused no pulse", 64'(bc_sq[0]), 64'd0);
        chk("R1 youngest kept", 64'(yg(0)), 64'd10);

        // R3 accepted squash
        push(0, 8, 32'h100, 1'b1);
        ex_sq_vld[0] = 1; ex_sq_seq[0 +: SW] = 8; ex_sq_pc[0 +: PW] = 32'h100; cyc();
        ex_sq_vld = 0; ex_sq_mispred = 0;
        chk("R3 state robsq", 64'(st(0)), 64'd2);
        chk("R3 youngest", 64'(yg(0)), 64'd8);
        chk("R9 counter after mispred", 64'(mispred_cnt), 64'd1);
        ren_vld = 1; ren_tid = 0; ren_seq = 30; cyc();
        ren_vld = 0;
        chk("R8 rename during robsq ignored", 64'(yg(0)), 64'd8);
        chk("R7 robsq flag", 64'(bc_robsq[0]), 64'd1);
        cyc();
        chk("R7 robsq flag held", 64'(bc_robsq[0]), 64'd1);
        rob_sq_done[0] = 1; cyc(); rob_sq_done = 0;
        chk("R7 back to running", 64'(st(0)), 64'd1);
        chk("R7 robsq flag low", 64'(bc_robsq[0]), 64'd0);

        // R2 include-self
        push(0, 4, 32'h200, 1'b0);
        ex_sq_vld[0] = 1; ex_sq_seq[0 +: SW] = 5; ex_sq_self[0] = 1; ex_sq_pc[0 +: PW] = 32'h200; cyc();
        ex_sq_vld = 0; ex_sq_self = 0;
        chk("R2 youngest minus one", 64'(yg(0)), 64'd4);
        chk("R9 counter unchanged", 64'(mispred_cnt), 64'd1);
        rob_sq_done[0] = 1; cyc(); rob_sq_done = 0;

        // R1 boundary: equal accepted
        push(1, 20, 32'h300, 1'b1);
        ex_sq_vld[1] = 1; ex_sq_seq[SW +: SW] = 20; ex_sq_mispred[1] = 1; ex_sq_pc[PW +: PW] = 32'h300; cyc();
        ex_sq_vld = 0; ex_sq_mispred = 0;
        chk("R1 equal accepted", 64'(st(1)), 64'd2);
        chk("R9 counter t1", 64'(mispred_cnt), 64'd2);
        rob_sq_done[1] = 1; cyc(); rob_sq_done = 0;

        // R4/R6 trap latency 3
        rob_empty[0] = 0; rob_head_seq[0 +: SW] = 3; commit_pc[0 +: PW] = 32'h400; trap_lat = 3;
        trap_req[0] = 1; cyc(); trap_req = 0;
        chk("R4 trap wait state", 64'(st(0)), 64'd3);
        ex_sq_vld[0] = 1; ex_sq_seq[0 +: SW] = 0; cyc(); ex_sq_vld = 0;
        chk("R4 exec refused while waiting", 64'(bc_sq[0]), 64'd0);
        chk("R4 youngest kept while waiting", 64'(yg(0)), 64'd4);
        cyc();
        chk("R4 no early pulse", 64'(bc_sq[0]), 64'd0);
        push(0, 2, 32'h400, 1'b0);
        cyc();
        chk("R4 no early pulse L", 64'(bc_sq[0]), 64'd0);
        cyc();
        chk("R4 pulse at L+1", 64'(bc_sq[0]), 64'd1);
        chk("R6 youngest zero", 64'(yg(0)), 64'd0);
        chk("R6 robsq", 64'(st(0)), 64'd2);
        rob_sq_done[0] = 1; cyc(); rob_sq_done = 0;

        // R4 fetch trap, latency 0 treated as 1
        commit_pc[PW +: PW] = 32'h500; trap_lat = 0;
        trap_req[1] = 1; trap_fetch[1] = 1; cyc(); trap_req = 0; trap_fetch = 0;
        chk("R4 fetch trap state", 64'(st(1)), 64'd4);
        push(1, 0, 32'h500, 1'b0);
        cyc();
        chk("R4 lat0 no early pulse", 64'(bc_sq[1]), 64'd0);
        cyc();
        chk("R4 lat0 pulse", 64'(bc_sq[1]), 64'd1);
        rob_sq_done[1] = 1; cyc(); rob_sq_done = 0;

        // R5 trap and context together
        trap_lat = 1; trap_req[1] = 1; cyc(); trap_req = 0;
        ctx_sq_req[1] = 1; cyc(); ctx_sq_req = 0;
        chk("R5 no pulse yet", 64'(bc_sq[1]), 64'd0);
        push(1, 0, 32'h500, 1'b0);
        push(1, 0, 32'h500, 1'b0);
        cyc();
        chk("R5 trap pulse", 64'(bc_sq[1]), 64'd1);
        cyc();
        chk("R5 context pulse follows", 64'(bc_sq[1]), 64'd1);
        cyc();
        chk("R5 then quiet", 64'(bc_sq[1]), 64'd0);
        rob_sq_done[1] = 1; cyc(); rob_sq_done = 0;

        // R5/R6 lone context squash
        ren_vld = 1; ren_tid = 0; ren_seq = 60; cyc(); ren_vld = 0;
        chk("R8 rename in running", 64'(yg(0)), 64'd60);
        rob_head_seq[0 +: SW] = 50; commit_pc[0 +: PW] = 32'h600;
        ctx_sq_req[0] = 1; cyc(); ctx_sq_req = 0;
        chk("R5 ctx not yet", 64'(bc_sq[0]), 64'd0);
        push(0, 49, 32'h600, 1'b0);
        cyc();
        chk("R5 ctx pulse", 64'(bc_sq[0]), 64'd1);
        chk("R6 ctx youngest zero", 64'(yg(0)), 64'd0);
        rob_sq_done[0] = 1; cyc(); rob_sq_done = 0;

        thr_active[1] = 0; cyc();
        chk("R11 running to idle", 64'(st(1)), 64'd0);

        repeat (3) cyc();
        chk("R3 all expected pulses seen", 64'(sb.size()), 64'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule